// File: doc/BRIEF.md
# UART Byte Queue Control and Status

This block sits between a processor's register port and the serial shifters of a UART. It keeps one transmit queue and one receive queue, each sixteen bytes deep. Software fills the transmit queue by writing a buffer register. It empties the receive queue by reading another buffer register. The shifter side pulls bytes from the transmit queue with a valid/ready pair and pushes received bytes with a strobe.

Each queue has its own control register. The register holds an enable bit, a self-clearing flush bit and a six-bit trigger level. A single packed status word reports three values: the receive fill, the transmit fill and the transmit free space. Two request lines, one per direction, go to the interrupt unit. A sticky overrun flag marks a received byte that found no room. Register reads are combinational on the address. Every state change takes effect at the next rising clock edge.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset both queues are disabled with trigger level 0, both fills are 0, the overrun flag is low and both requests are low. The status word then reads 0x10000000, which is a transmit free count of 16.
- R2: The register map uses these word addresses: 0 is transmit control, 1 is receive control, 2 is status, 3 is transmit buffer (write only, reads 0) and 4 is receive buffer. Unused addresses read 0. In each control register, bit 0 is enable, bit 1 is flush and bits 13:8 are the trigger level. A control read returns the enable and the level, and bit 1 always reads 0.
- R3: A write to address 3 pushes wrData[7:0] into the transmit queue only when that queue is enabled and its fill count before the edge is below 16. Any other write to address 3 is dropped, and the fill never exceeds 16.
- R4: txPopValid is high exactly when the transmit queue is enabled and not empty. txPopData then shows the oldest byte, and that byte is removed at an edge where txPopReady is high.
- R5: A receive strobe stores rxPushData only when the receive queue is enabled and not full. A read at address 4 returns the oldest byte and removes it, whether or not the queue is enabled. A read of an empty receive queue returns 0 and changes nothing.
- R6: A receive strobe that arrives while the receive queue is enabled and full discards the byte and sets rxOverrun. The flag stays set until a receive flush clears it.
- R7: The status word at address 2 carries the receive fill in bits 5:0, the transmit fill in bits 13:8 and the transmit free count (16 minus the fill) in bits 29:24. All other bits are 0.
- R8: Writing 1 to a flush bit empties that queue at the next edge. A receive flush also clears rxOverrun and wins over a receive strobe in the same cycle.
- R9: rxReq is high while the receive queue is enabled and its fill is at or above the receive trigger level.
- R10: txReq is high while the transmit queue is enabled and its fill is at or below the transmit trigger level.
- R11: Both queues keep first-in first-out order across pointer wrap-around. A push and a pop in the same cycle both take effect, and the push is judged against the fill count before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops at address 4) |
| addr | input | 3 | Register word address |
| wrData | input | 14 | Write data (all writable fields live in bits 13:0) |
| rdData | output | 32 | Read data, combinational on addr |
| rxPushValid | input | 1 | Receive shifter delivers a byte |
| rxPushData | input | 8 | Received byte |
| txPopReady | input | 1 | Transmit shifter takes the head byte |
| txPopValid | output | 1 | Transmit queue has a byte for the shifter |
| txPopData | output | 8 | Oldest transmit byte |
| rxReq | output | 1 | Receive service request |
| txReq | output | 1 | Transmit service request |
| rxOverrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench targets the fill-count boundaries, writes and strobes against a full queue, and the flush bit. A design that checks fullness after a same-cycle pop would accept a seventeenth byte and corrupt the free count. A flush that loses to a receive strobe would leave one stale byte behind. Off-by-one comparisons in the request logic show up in the level sweep, including level 0 and level 63. Long mixed traffic wraps the pointers many times and catches any reordering of bytes.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int REG_AW = 3;
  localparam int WR_W   = 14;
  localparam int RD_W   = 32;
  localparam int FLD_W  = 6;

  localparam logic [REG_AW-1:0] ADDR_TXCTL = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_RXCTL = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_TXBUF = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_RXBUF = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobe_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wrByte,
  output logic [DW-1:0] headByte,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign headByte = mem[rdPtr];
endmodule

// File: rtl/uart_fifo_dp.sv
module uart_fifo_dp import uart_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [DW-1:0] txWrByte,
  input  logic [DW-1:0] rxWrByte,
  output logic [DW-1:0] txHead,
  output logic [DW-1:0] rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(strobe.txPop), .flush(strobe.txFlush),
    .wrByte(txWrByte), .headByte(txHead), .count(txCount)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pop(strobe.rxPop), .flush(strobe.rxFlush),
    .wrByte(rxWrByte), .headByte(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl import uart_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [WR_W-1:0]   wrData,
  input  logic              rxPushValid,
  input  logic              txPopReady,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [DW-1:0]     rxHead,
  output fifoStrobe_t       strobe,
  output logic [RD_W-1:0]   rdData,
  output logic              txPopValid,
  output logic              rxReq,
  output logic              txReq,
  output logic              rxOverrun,
  output logic              txEn,
  output logic              rxEn
);
  logic [FLD_W-1:0] txLvl, rxLvl;
  logic [CW-1:0]    txFree;
  logic wrTxCtl, wrRxCtl, wrTxBuf, rdRxBuf;
  logic txFull, rxFull, txEmpty, rxEmpty;

  assign wrTxCtl = wrEn && (addr == ADDR_TXCTL);
  assign wrRxCtl = wrEn && (addr == ADDR_RXCTL);
  assign wrTxBuf = wrEn && (addr == ADDR_TXBUF);
  assign rdRxBuf = rdEn && (addr == ADDR_RXBUF);

  assign txFull  = (txCount == CW'(DEPTH));
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);
  assign txFree  = CW'(DEPTH) - txCount;

  assign txPopValid = txEn && !txEmpty;

  always_comb begin
    strobe         = '0;
    strobe.txFlush = wrTxCtl && wrData[1];
    strobe.rxFlush = wrRxCtl && wrData[1];
    strobe.txPush  = wrTxBuf && txEn && !txFull;
    strobe.txPop   = txPopValid && txPopReady;
    strobe.rxPush  = rxPushValid && rxEn && !rxFull && !strobe.rxFlush;
    strobe.rxPop   = rdRxBuf && !rxEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn      <= 1'b0;
      rxEn      <= 1'b0;
      txLvl     <= '0;
      rxLvl     <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (wrTxCtl) begin
        txEn  <= wrData[0];
        txLvl <= wrData[13:8];
      end
      if (wrRxCtl) begin
        rxEn  <= wrData[0];
        rxLvl <= wrData[13:8];
      end
      if (strobe.rxFlush)
        rxOverrun <= 1'b0;
      else if (rxPushValid && rxEn && rxFull)
        rxOverrun <= 1'b1;
    end
  end

  assign rxReq = rxEn && (int'(rxCount) >= int'(rxLvl));
  assign txReq = txEn && (int'(txCount) <= int'(txLvl));

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_TXCTL: begin
        rdData[0]    = txEn;
        rdData[13:8] = txLvl;
      end
      ADDR_RXCTL: begin
        rdData[0]    = rxEn;
        rdData[13:8] = rxLvl;
      end
      ADDR_STAT: begin
        rdData[5:0]   = FLD_W'(rxCount);
        rdData[13:8]  = FLD_W'(txCount);
        rdData[29:24] = FLD_W'(txFree);
      end
      ADDR_RXBUF: begin
        if (!rxEmpty) rdData[DW-1:0] = rxHead;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs import uart_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [WR_W-1:0]   wrData,
  output logic [RD_W-1:0]   rdData,
  input  logic              rxPushValid,
  input  logic [DW-1:0]     rxPushData,
  input  logic              txPopReady,
  output logic              txPopValid,
  output logic [DW-1:0]     txPopData,
  output logic              rxReq,
  output logic              txReq,
  output logic              rxOverrun
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t   strobe;
  logic [CW-1:0] txCount, rxCount;
  logic [DW-1:0] rxHead;
  logic          txEn, rxEn;

  uart_fifo_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rxPushValid(rxPushValid), .txPopReady(txPopReady),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobe(strobe), .rdData(rdData), .txPopValid(txPopValid),
    .rxReq(rxReq), .txReq(txReq), .rxOverrun(rxOverrun),
    .txEn(txEn), .rxEn(rxEn)
  );

  uart_fifo_dp #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrByte(wrData[DW-1:0]), .rxWrByte(rxPushData),
    .txHead(txPopData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk import uart_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [REG_AW-1:0] addr,
  input logic [WR_W-1:0]   wrData,
  input logic              rxPushValid,
  input logic              txPopReady,
  input logic              txPopValid,
  input logic              rxOverrun,
  input logic [CW-1:0]     txCount,
  input logic [CW-1:0]     rxCount,
  input logic              rxEn
);
  logic rxFlushWr, txFlushWr;
  assign rxFlushWr = wrEn && (addr == ADDR_RXCTL) && wrData[1];
  assign txFlushWr = wrEn && (addr == ADDR_TXCTL) && wrData[1];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CW'(DEPTH)) && !(txPopValid && txPopReady) && !txFlushWr
    |=> txCount == CW'(DEPTH));

  p_pop_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    txPopValid |-> txCount != '0);

  p_rx_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (addr == ADDR_RXBUF) && (rxCount != '0) && !rxPushValid
    |=> rxCount == $past(rxCount) - CW'(1));

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxPushValid && rxEn && (rxCount == CW'(DEPTH)) && !rxFlushWr |=> rxOverrun);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxFlushWr |=> (rxCount == '0) && !rxOverrun);
endmodule

bind uart_fifo_regs uart_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rxPushValid(rxPushValid), .txPopReady(txPopReady),
  .txPopValid(txPopValid), .rxOverrun(rxOverrun),
  .txCount(txCount), .rxCount(rxCount), .rxEn(rxEn)
);

// File: tb/tb_uart_fifo_regs.sv
`timescale 1ns/1ps
module tb_uart_fifo_regs;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [13:0] wrData = '0;
  logic [31:0] rdData;
  logic        rxPushValid = 1'b0;
  logic [7:0]  rxPushData = '0;
  logic        txPopReady = 1'b0;
  logic        txPopValid;
  logic [7:0]  txPopData;
  logic        rxReq, txReq, rxOverrun;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_fifo_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxPushValid(rxPushValid),
    .rxPushData(rxPushData), .txPopReady(txPopReady), .txPopValid(txPopValid),
    .txPopData(txPopData), .rxReq(rxReq), .txReq(txReq), .rxOverrun(rxOverrun)
  );

  // behavioural reference model
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit mTxEn, mRxEn, mOvr;
  int mTxLvl, mRxLvl;

  task automatic chk(input string ctx, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = (32'(mTxLvl) << 8) | 32'(mTxEn);
      3'd1: v = (32'(mRxLvl) << 8) | 32'(mRxEn);
      3'd2: v = 32'(rxQ.size()) | (32'(txQ.size()) << 8) | (32'(DEPTH - txQ.size()) << 24);
      3'd4: v = (rxQ.size() > 0) ? 32'(rxQ[0]) : 32'd0;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic compareAll(input string ctx);
    string rtag;
    chk(ctx, "R4", 32'(txPopValid), 32'(mTxEn && txQ.size() > 0));
    if (mTxEn && txQ.size() > 0) chk(ctx, "R4 data", 32'(txPopData), 32'(txQ[0]));
    chk(ctx, "R9", 32'(rxReq), 32'(mRxEn && rxQ.size() >= mRxLvl));
    chk(ctx, "R10", 32'(txReq), 32'(mTxEn && txQ.size() <= mTxLvl));
    chk(ctx, "R6", 32'(rxOverrun), 32'(mOvr));
    case (addr)
      3'd0, 3'd1: rtag = "R2";
      3'd2: rtag = "R7";
      3'd4: rtag = "R5";
      default: rtag = "R2 unmapped";
    endcase
    chk(ctx, rtag, rdData, expRead(addr));
  endtask

  task automatic modelEdge();
    bit flT, flR, pushT, popT, pushR, popR, ovrSet;
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mTxEn = 0; mRxEn = 0; mOvr = 0; mTxLvl = 0; mRxLvl = 0;
      return;
    end
    flT    = wrEn && addr == 3'd0 && wrData[1];
    flR    = wrEn && addr == 3'd1 && wrData[1];
    pushT  = wrEn && addr == 3'd3 && mTxEn && txQ.size() < DEPTH;
    popT   = txPopReady && mTxEn && txQ.size() > 0;
    popR   = rdEn && addr == 3'd4 && rxQ.size() > 0;
    pushR  = rxPushValid && mRxEn && rxQ.size() < DEPTH && !flR;
    ovrSet = rxPushValid && mRxEn && rxQ.size() == DEPTH && !flR;
    if (flT) txQ.delete();
    else begin
      if (popT) void'(txQ.pop_front());
      if (pushT) txQ.push_back(wrData[7:0]);
    end
    if (flR) begin
      rxQ.delete(); mOvr = 0;
    end else begin
      if (popR) void'(rxQ.pop_front());
      if (pushR) rxQ.push_back(rxPushData);
      if (ovrSet) mOvr = 1;
    end
    if (wrEn && addr == 3'd0) begin mTxEn = wrData[0]; mTxLvl = int'(wrData[13:8]); end
    if (wrEn && addr == 3'd1) begin mRxEn = wrData[0]; mRxLvl = int'(wrData[13:8]); end
  endtask

  // inputs change at negedge, outputs compared 1 ns later, model updates at posedge
  task automatic step(input string ctx);
    #1;
    if (rstN) compareAll(ctx);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; addr = 3'd2; wrData = '0;
    rxPushValid = 0; txPopReady = 0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [13:0] d, input string ctx);
    idle(); wrEn = 1; addr = a; wrData = d; step(ctx); idle();
  endtask

  task automatic regRead(input logic [2:0] a, input string ctx);
    idle(); rdEn = 1; addr = a; step(ctx); idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    repeat (3) step("reset");
    rstN = 1;
    // R1: reset values through the register port
    regRead(3'd0, "R1 reset txctl");
    regRead(3'd1, "R1 reset rxctl");
    regRead(3'd2, "R1 reset status");
    regRead(3'd4, "R1 reset rxbuf");
    regRead(3'd5, "R1 reset unmapped");
    // R3: writes while disabled are dropped
    regWrite(3'd3, 14'h0055, "R3 disabled drop");
    regRead(3'd2, "R3 disabled status");
    // R5: receive strobe while disabled is ignored
    idle(); rxPushValid = 1; rxPushData = 8'h77; step("R5 disabled rx"); idle();
    regRead(3'd2, "R5 disabled rx status");
    // R2: enable with flush, flush reads back 0
    regWrite(3'd0, 14'h0403, "R2 txctl write");
    regRead(3'd0, "R2 txctl readback");
    regWrite(3'd1, 14'h0303, "R2 rxctl write");
    regRead(3'd1, "R2 rxctl readback");
    // R3: fill transmit queue beyond capacity
    for (int i = 0; i < 18; i++)
      regWrite(3'd3, 14'(8'hA0 + i), "R3 tx fill");
    regRead(3'd2, "R3 full status");
    // R11 / R4: drain with concurrent pushes, wrap pointers
    for (int i = 0; i < 40; i++) begin
      idle(); txPopReady = 1;
      if (i % 2 == 0 && i < 24) begin wrEn = 1; addr = 3'd3; wrData = 14'(8'h10 + i); end
      step("R11 wrap order");
    end
    idle();
    // R6: overfill receive queue
    for (int i = 0; i < 18; i++) begin
      idle(); rxPushValid = 1; rxPushData = 8'(8'h30 + i); step("R6 overrun");
    end
    idle();
    regRead(3'd2, "R6 status");
    // R5: read out all plus one empty read
    for (int i = 0; i < 17; i++) regRead(3'd4, "R5 rx read");
    regRead(3'd2, "R5 empty status");
    // R8: flush receive with concurrent strobe, flush transmit holding data
    for (int i = 0; i < 5; i++) begin
      idle(); rxPushValid = 1; rxPushData = 8'(i); step("R8 prefill");
    end
    regWrite(3'd3, 14'h00C1, "R8 tx prefill");
    regWrite(3'd3, 14'h00C2, "R8 tx prefill");
    idle(); wrEn = 1; addr = 3'd1; wrData = 14'h0303; rxPushValid = 1; rxPushData = 8'hEE;
    step("R8 rx flush vs push"); idle();
    regRead(3'd2, "R8 rx after flush");
    regWrite(3'd0, 14'h0403, "R8 tx flush");
    regRead(3'd2, "R8 tx after flush");
    // R9 / R10: level sweep incl. extremes
    regWrite(3'd1, 14'h0001, "R9 level 0");
    regWrite(3'd0, 14'h3F01, "R10 level 63");
    for (int i = 0; i < 4; i++) begin
      idle(); rxPushValid = 1; rxPushData = 8'(i); wrEn = 1; addr = 3'd3; wrData = 14'(i);
      step("R9 R10 sweep");
    end
    regWrite(3'd1, 14'h3F01, "R9 level 63");
    regWrite(3'd0, 14'h0001, "R10 level 0");
    regWrite(3'd1, 14'h0201, "R9 level 2");
    regWrite(3'd0, 14'h0201, "R10 level 2");
    regRead(3'd2, "R9 R10 status");
    // R11: mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      idle();
      txPopReady = ($urandom % 3) != 0;
      rxPushValid = ($urandom % 2) != 0;
      rxPushData = 8'($urandom);
      if (r < 40) begin wrEn = 1; addr = 3'd3; wrData = 14'($urandom); end
      else if (r < 75) begin rdEn = 1; addr = 3'd4; end
      else if (r < 77) begin wrEn = 1; addr = 3'd1; wrData = {6'($urandom), 7'd0, 1'b1} | 14'(($urandom % 4 == 0) ? 2 : 0); end
      else if (r < 79) begin wrEn = 1; addr = 3'd0; wrData = {6'($urandom), 7'd0, 1'b1} | 14'(($urandom % 4 == 0) ? 2 : 0); end
      else addr = 3'(r % 6);
      step("R11 mixed traffic");
    end
    idle();
    regRead(3'd2, "R7 final status");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule